// File: doc/BRIEF.md
# Configuration Stream DMA Command Engine

This block is a single-channel DMA engine that fetches 32-bit words from memory and pushes them, one at a time and in ascending address order, into a configuration data port. Software describes each transfer by writing four registers: a source address, a destination address, a source length in words, and a destination length. A command is built only when these four writes arrive in that exact order. The destination write-back path is unused here, so the destination registers must carry the "no write-back" pair.

Accepted commands wait in a four-entry in-order queue. A word mover takes commands from the queue. It reads memory through a valid/ready request channel and a valid/ready response channel, and holds each fetched word in a one-word output register until the port accepts it. Bit 0 of the source address marks the final transfer of a configuration image. The mover reports completion of that transfer only after the port has taken every word, and at the same moment it reports that the port has finished. The engine signals completion, overflow, rejection and read errors toward an interrupt unit as single-cycle pulses.

Back-pressure rules: `cfg_valid` stays high and `cfg_data` holds steady until `cfg_ready` is seen high at a clock edge. `rd_req_valid` and `rd_req_addr` hold steady until `rd_req_ready` is seen high. A response counts only in a cycle where both `rd_rsp_valid` and `rd_rsp_ready` are high. At most one read is outstanding at any time.

Top module: `cfg_dma_engine`

## Requirements
- R1: Register offsets are 0x18 (source address), 0x1C (destination address), 0x20 (source length) and 0x24 (destination length). A command is queued only by a destination-length write that follows source address, destination address and source length in that order. A source-address write always restarts the sequence. Any other write out of order cancels it, and the final write then queues nothing.
- R2: The source length counts 32-bit words and uses the low 27 bits of the written value, so the largest length is 0x7FFFFFF and higher bits are ignored. A zero length completes the command with no memory reads.
- R3: When bit 0 of the source address is 1, the command's done pulse comes only after the port has accepted every word of that command. It comes together with a port-done pulse, and `cfg_valid` is low at that time.
- R4: When bit 0 of the source address is 0, the done pulse follows the arrival of the final word from memory, even if the port has not yet accepted it. No port-done pulse is raised.
- R5: A completed sequence is accepted only with destination address 0xFFFFFFFF and destination length 0. Any other destination raises a command-reject pulse and queues nothing.
- R6: The queue holds 4 commands, which run in the order written. `status_word` bit 31 is 1 when the queue is full, bit 30 is 1 when it is empty, and all other bits are 0.
- R7: A valid command completed while the queue is full raises a queue-overflow pulse and is dropped. Commands already queued are not affected.
- R8: Memory reads use word addresses: the low two bits of the source address are ignored, request addresses have bits [1:0] equal to 0, and successive reads step up by 4 bytes.
- R9: An error response aborts the current command. It raises a read-error pulse, raises no done pulse for that command, and forwards no data from the failed read. The next queued command then runs normally.
- R10: While the port holds `cfg_ready` low, the engine keeps `cfg_valid` high and `cfg_data` unchanged. No word is lost or reordered under any pattern of back-pressure.
- R11: After reset `status_word` is 0x40000000, `cfg_valid` and `rd_req_valid` are low, and no event pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register byte offset |
| reg_wr_data | input | 32 | Register write data |
| status_word | output | 32 | Bit 31 queue full, bit 30 queue empty |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 32 | Word-aligned read byte address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Engine can take a response |
| rd_rsp_data | input | 32 | Read response data |
| rd_rsp_err | input | 1 | Read response carries an error |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_ready | input | 1 | Configuration port accepts a word |
| cfg_data | output | 32 | Configuration word |
| evt_dma_done | output | 1 | Command finished (pulse) |
| evt_port_done | output | 1 | Last command drained through the port (pulse) |
| evt_rd_err | output | 1 | Command aborted on read error (pulse) |
| evt_q_overflow | output | 1 | Command dropped, queue full (pulse) |
| evt_cmd_err | output | 1 | Command rejected, bad destination (pulse) |

## Verification
The bench stalls the port for a flagged last transfer and checks that done arrives only after the final word is taken. A design that reported done on the last read would raise it with words still unsent. It also fills the queue behind a stalled port, checks the full status and overflow drop, and then checks that all six queued commands drain in order; a wrong depth or pointer wrap would lose or repeat words. Further directed cases cover skipped sequence steps, a source-address restart, bad destinations, zero and over-wide lengths, misaligned source addresses, and a mid-command read error. These expose a design that queues on any final write, counts bytes, or signals done after an abort.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

  // Default register byte offsets; software writes them in this order.
  localparam logic [7:0] DEF_OFF_SRC_ADDR = 8'h18;
  localparam logic [7:0] DEF_OFF_DST_ADDR = 8'h1C;
  localparam logic [7:0] DEF_OFF_SRC_LEN  = 8'h20;
  localparam logic [7:0] DEF_OFF_DST_LEN  = 8'h24;

  // Progress through the four-write launch sequence.
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_HAVE_SRC,
    SQ_HAVE_DST,
    SQ_HAVE_LEN
  } sq_step_e;

  // Word mover states.
  typedef enum logic [1:0] {
    MV_IDLE,
    MV_REQ,
    MV_WAIT,
    MV_FINISH
  } mv_state_e;

endpackage

// File: rtl/cfg_dma_regseq.sv
module cfg_dma_regseq
  import cfg_dma_pkg::*;
#(
  parameter int               AW       = 32,
  parameter int               DW       = 32,
  parameter int               LEN_W    = 27,
  parameter int               REG_AW   = 8,
  parameter logic [REG_AW-1:0] OFF_SRC  = DEF_OFF_SRC_ADDR,
  parameter logic [REG_AW-1:0] OFF_DST  = DEF_OFF_DST_ADDR,
  parameter logic [REG_AW-1:0] OFF_SLEN = DEF_OFF_SRC_LEN,
  parameter logic [REG_AW-1:0] OFF_DLEN = DEF_OFF_DST_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              q_full,
  output logic              push,
  output logic [AW-3:0]     push_waddr,
  output logic              push_last,
  output logic [LEN_W-1:0]  push_len,
  output logic              evt_q_overflow,
  output logic              evt_cmd_err
);

  sq_step_e           step_q;
  logic [AW-3:0]      waddr_q;
  logic               last_q;
  logic [DW-1:0]      dst_q;
  logic [LEN_W-1:0]   len_q;

  logic hit_dlen, seq_complete, dst_ok;

  assign hit_dlen     = wr_en && (wr_addr == OFF_DLEN);
  assign seq_complete = hit_dlen && (step_q == SQ_HAVE_LEN);
  assign dst_ok       = (dst_q == {DW{1'b1}}) && (wr_data == '0);

  assign push       = seq_complete && dst_ok && !q_full;
  assign push_waddr = waddr_q;
  assign push_last  = last_q;
  assign push_len   = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q         <= SQ_IDLE;
      waddr_q        <= '0;
      last_q         <= 1'b0;
      dst_q          <= '0;
      len_q          <= '0;
      evt_q_overflow <= 1'b0;
      evt_cmd_err    <= 1'b0;
    end else begin
      evt_q_overflow <= 1'b0;
      evt_cmd_err    <= 1'b0;
      if (wr_en) begin
        if (wr_addr == OFF_SRC) begin
          waddr_q <= wr_data[AW-1:2];
          last_q  <= wr_data[0];
          step_q  <= SQ_HAVE_SRC;
        end else if (wr_addr == OFF_DST) begin
          if (step_q == SQ_HAVE_SRC) begin
            dst_q  <= wr_data;
            step_q <= SQ_HAVE_DST;
          end else begin
            step_q <= SQ_IDLE;
          end
        end else if (wr_addr == OFF_SLEN) begin
          if (step_q == SQ_HAVE_DST) begin
            len_q  <= wr_data[LEN_W-1:0];
            step_q <= SQ_HAVE_LEN;
          end else begin
            step_q <= SQ_IDLE;
          end
        end else if (wr_addr == OFF_DLEN) begin
          step_q <= SQ_IDLE;
          if (step_q == SQ_HAVE_LEN) begin
            if (!dst_ok)
              evt_cmd_err <= 1'b1;
            else if (q_full)
              evt_q_overflow <= 1'b1;
          end
        end
      end
    end
  end

  // R7 and R5 outcomes of one final write are exclusive
  p_ovf_vs_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_q_overflow && evt_cmd_err));

  // R1: a queued command always comes from a completed in-order sequence
  p_push_needs_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (wr_en && step_q == SQ_HAVE_LEN));

endmodule

// File: rtl/cfg_dma_cmdq.sv
module cfg_dma_cmdq #(
  parameter int W     = 58,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push)
      mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push)
        wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
      if (do_pop)
        rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_empty_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R6: the mover only takes a command that exists
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R7: the sequencer never offers a command into a full queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/cfg_dma_mover.sv
module cfg_dma_mover
  import cfg_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty,
  input  logic [AW-3:0]    q_waddr,
  input  logic             q_last,
  input  logic [LEN_W-1:0] q_len,
  output logic             q_pop,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [AW-1:0]    rd_req_addr,
  input  logic             rd_rsp_valid,
  output logic             rd_rsp_ready,
  input  logic [DW-1:0]    rd_rsp_data,
  input  logic             rd_rsp_err,
  output logic             cfg_valid,
  input  logic             cfg_ready,
  output logic [DW-1:0]    cfg_data,
  output logic             evt_dma_done,
  output logic             evt_port_done,
  output logic             evt_rd_err
);

  mv_state_e        st;
  logic [AW-3:0]    waddr;
  logic [LEN_W-1:0] remaining;
  logic             is_last;
  logic             out_valid;
  logic [DW-1:0]    out_data;

  assign q_pop        = (st == MV_IDLE) && !q_empty;
  assign rd_req_valid = (st == MV_REQ) && !out_valid;
  assign rd_req_addr  = {waddr, 2'b00};
  assign rd_rsp_ready = (st == MV_WAIT);
  assign cfg_valid    = out_valid;
  assign cfg_data     = out_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= MV_IDLE;
      waddr         <= '0;
      remaining     <= '0;
      is_last       <= 1'b0;
      out_valid     <= 1'b0;
      out_data      <= '0;
      evt_dma_done  <= 1'b0;
      evt_port_done <= 1'b0;
      evt_rd_err    <= 1'b0;
    end else begin
      evt_dma_done  <= 1'b0;
      evt_port_done <= 1'b0;
      evt_rd_err    <= 1'b0;
      if (out_valid && cfg_ready)
        out_valid <= 1'b0;
      case (st)
        MV_IDLE: begin
          if (!q_empty) begin
            waddr     <= q_waddr;
            remaining <= q_len;
            is_last   <= q_last;
            st        <= (q_len == '0) ? MV_FINISH : MV_REQ;
          end
        end
        MV_REQ: begin
          if (rd_req_valid && rd_req_ready)
            st <= MV_WAIT;
        end
        MV_WAIT: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_err) begin
              evt_rd_err <= 1'b1;
              st         <= MV_IDLE;
            end else begin
              out_valid <= 1'b1;
              out_data  <= rd_rsp_data;
              waddr     <= waddr + 1'b1;
              remaining <= remaining - 1'b1;
              st        <= (remaining == LEN_W'(1)) ? MV_FINISH : MV_REQ;
            end
          end
        end
        MV_FINISH: begin
          if (!is_last) begin
            evt_dma_done <= 1'b1;
            st           <= MV_IDLE;
          end else if (!out_valid) begin
            evt_dma_done  <= 1'b1;
            evt_port_done <= 1'b1;
            st            <= MV_IDLE;
          end
        end
        default: st <= MV_IDLE;
      endcase
    end
  end

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data)));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  p_req_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[1:0] == 2'b00));

  p_port_drained_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_port_done |-> (evt_dma_done && !cfg_valid));

  p_err_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_err |-> !evt_dma_done);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dma_done |=> !evt_dma_done);

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
#(
  parameter int               AW       = 32,
  parameter int               DW       = 32,
  parameter int               LEN_W    = 27,
  parameter int               QDEPTH   = 4,
  parameter int               REG_AW   = 8,
  parameter logic [REG_AW-1:0] OFF_SRC  = DEF_OFF_SRC_ADDR,
  parameter logic [REG_AW-1:0] OFF_DST  = DEF_OFF_DST_ADDR,
  parameter logic [REG_AW-1:0] OFF_SLEN = DEF_OFF_SRC_LEN,
  parameter logic [REG_AW-1:0] OFF_DLEN = DEF_OFF_DST_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_wr_addr,
  input  logic [DW-1:0]     reg_wr_data,
  output logic [31:0]       status_word,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DW-1:0]     rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [DW-1:0]     cfg_data,
  output logic              evt_dma_done,
  output logic              evt_port_done,
  output logic              evt_rd_err,
  output logic              evt_q_overflow,
  output logic              evt_cmd_err
);

  localparam int ENTRY_W = (AW - 2) + 1 + LEN_W;

  logic               push, q_full, q_empty, q_pop;
  logic [AW-3:0]      push_waddr, q_waddr;
  logic               push_last, q_last;
  logic [LEN_W-1:0]   push_len, q_len;
  logic [ENTRY_W-1:0] q_din, q_dout;

  cfg_dma_regseq #(
    .AW(AW), .DW(DW), .LEN_W(LEN_W), .REG_AW(REG_AW),
    .OFF_SRC(OFF_SRC), .OFF_DST(OFF_DST), .OFF_SLEN(OFF_SLEN), .OFF_DLEN(OFF_DLEN)
  ) u_regseq (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (reg_wr_en),
    .wr_addr        (reg_wr_addr),
    .wr_data        (reg_wr_data),
    .q_full         (q_full),
    .push           (push),
    .push_waddr     (push_waddr),
    .push_last      (push_last),
    .push_len       (push_len),
    .evt_q_overflow (evt_q_overflow),
    .evt_cmd_err    (evt_cmd_err)
  );

  assign q_din = {push_waddr, push_last, push_len};
  assign {q_waddr, q_last, q_len} = q_dout;

  cfg_dma_cmdq #(.W(ENTRY_W), .DEPTH(QDEPTH)) u_cmdq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (q_din),
    .pop   (q_pop),
    .dout  (q_dout),
    .full  (q_full),
    .empty (q_empty)
  );

  cfg_dma_mover #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_mover (
    .clk           (clk),
    .rst_n         (rst_n),
    .q_empty       (q_empty),
    .q_waddr       (q_waddr),
    .q_last        (q_last),
    .q_len         (q_len),
    .q_pop         (q_pop),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_req_addr   (rd_req_addr),
    .rd_rsp_valid  (rd_rsp_valid),
    .rd_rsp_ready  (rd_rsp_ready),
    .rd_rsp_data   (rd_rsp_data),
    .rd_rsp_err    (rd_rsp_err),
    .cfg_valid     (cfg_valid),
    .cfg_ready     (cfg_ready),
    .cfg_data      (cfg_data),
    .evt_dma_done  (evt_dma_done),
    .evt_port_done (evt_port_done),
    .evt_rd_err    (evt_rd_err)
  );

  assign status_word = {q_full, q_empty, 30'b0};

  // R6: status never reports full and empty together
  p_status_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_word[31] && status_word[30]));

endmodule

// File: tb/cfg_dma_engine_tb.sv
module cfg_dma_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam logic [7:0] A_SRC  = 8'h18;
  localparam logic [7:0] A_DST  = 8'h1C;
  localparam logic [7:0] A_SLEN = 8'h20;
  localparam logic [7:0] A_DLEN = 8'h24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] status_word;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready, rd_rsp_err;
  logic [31:0] rd_req_addr, rd_rsp_data, cfg_data;
  logic        cfg_valid, cfg_ready;
  logic        evt_dma_done, evt_port_done, evt_rd_err, evt_q_overflow, evt_cmd_err;

  cfg_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .status_word(status_word),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .evt_dma_done(evt_dma_done), .evt_port_done(evt_port_done),
    .evt_rd_err(evt_rd_err), .evt_q_overflow(evt_q_overflow), .evt_cmd_err(evt_cmd_err)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0F0F_0000;
  endfunction

  // Memory model: one read at a time, fixed latency.
  logic [31:0] cyc = '0;
  logic        mem_busy = 1'b0;
  logic        mem_slow = 1'b0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] mem_addr = '0;
  logic        rsp_v = 1'b0;
  int          lat = 0;
  int          req_cnt = 0;
  int          bad_align = 0;

  assign rd_req_ready = !mem_busy && (!mem_slow || cyc[0]);
  assign rd_rsp_valid = rsp_v;
  assign rd_rsp_data  = mem_word(mem_addr);
  assign rd_rsp_err   = (mem_addr == err_addr);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_busy <= 1'b0;
      rsp_v    <= 1'b0;
      lat      <= 0;
    end else begin
      if (rd_req_valid && rd_req_ready) begin
        mem_busy <= 1'b1;
        lat      <= 2;
        mem_addr <= rd_req_addr;
        req_cnt  <= req_cnt + 1;
        if (rd_req_addr[1:0] != 2'b00) bad_align <= bad_align + 1;
      end else if (mem_busy && !rsp_v) begin
        if (lat == 0) rsp_v <= 1'b1;
        else lat <= lat - 1;
      end
      if (rsp_v && rd_rsp_ready) begin
        rsp_v    <= 1'b0;
        mem_busy <= 1'b0;
      end
    end
  end

  // Port sink: 0 always ready, 1 never ready, 2 toggling.
  logic [1:0] sink_mode = 2'd0;
  assign cfg_ready = (sink_mode == 2'd0) || ((sink_mode == 2'd2) && cyc[1]);

  // Monitor
  logic [31:0] got [256];
  int acc_cnt = 0, done_cnt = 0, pdone_cnt = 0, rerr_cnt = 0, ovf_cnt = 0, cerr_cnt = 0;
  int acc_at_done = 0;
  int evt_at_reset = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (cfg_valid && cfg_ready) begin
        got[acc_cnt % 256] <= cfg_data;
        acc_cnt <= acc_cnt + 1;
      end
      if (evt_dma_done) begin
        done_cnt    <= done_cnt + 1;
        acc_at_done <= acc_cnt;
      end
      if (evt_port_done)  pdone_cnt <= pdone_cnt + 1;
      if (evt_rd_err)     rerr_cnt  <= rerr_cnt + 1;
      if (evt_q_overflow) ovf_cnt   <= ovf_cnt + 1;
      if (evt_cmd_err)    cerr_cnt  <= cerr_cnt + 1;
    end
  end

  int s_acc, s_done, s_pdone, s_rerr, s_ovf, s_cerr, s_req;

  task automatic snap();
    @(negedge clk);
    s_acc = acc_cnt; s_done = done_cnt; s_pdone = pdone_cnt; s_rerr = rerr_cnt;
    s_ovf = ovf_cnt; s_cerr = cerr_cnt; s_req = req_cnt;
  endtask

  task automatic chk_eq(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_words(input string tag, input int base, input logic [31:0] start, input int n);
    for (int i = 0; i < n; i++)
      chk_eq(tag, $sformatf("word %0d", i), got[(base + i) % 256],
             mem_word({start[31:2], 2'b00} + 32'(4 * i)));
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic send_cmd(input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] len, input logic [31:0] dlen);
    wr_reg(A_SRC, src);
    wr_reg(A_DST, dst);
    wr_reg(A_SLEN, len);
    wr_reg(A_DLEN, dlen);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R11", "status after reset", status_word, 32'h4000_0000);
    chk_eq("R11", "cfg_valid after reset", {31'b0, cfg_valid}, 32'd0);
    chk_eq("R11", "rd_req_valid after reset", {31'b0, rd_req_valid}, 32'd0);
    chk_eq("R11", "events after reset", 32'(evt_at_reset), 32'd0);
  endtask

  task automatic t_last_cmd();
    snap();
    send_cmd(32'h0000_1001, 32'hFFFF_FFFF, 32'd3, 32'd0);
    settle(150);
    chk_eq("R1", "words from ordered sequence", 32'(acc_cnt - s_acc), 32'd3);
    chk_words("R1", s_acc, 32'h0000_1000, 3);
    chk_eq("R3", "done count", 32'(done_cnt - s_done), 32'd1);
    chk_eq("R3", "port done count", 32'(pdone_cnt - s_pdone), 32'd1);
    chk_eq("R3", "words taken before done", 32'(acc_at_done - s_acc), 32'd3);
  endtask

  task automatic t_misaligned();
    snap();
    send_cmd(32'h0000_2003, 32'hFFFF_FFFF, 32'd2, 32'd0);
    settle(150);
    chk_eq("R8", "word count", 32'(acc_cnt - s_acc), 32'd2);
    chk_words("R8", s_acc, 32'h0000_2000, 2);
    chk_eq("R8", "unaligned requests", 32'(bad_align), 32'd0);
  endtask

  task automatic t_nonlast_stall();
    sink_mode = 2'd1;
    snap();
    send_cmd(32'h0000_3000, 32'hFFFF_FFFF, 32'd1, 32'd0);
    settle(100);
    chk_eq("R4", "done while port stalled", 32'(done_cnt - s_done), 32'd1);
    chk_eq("R4", "no port done", 32'(pdone_cnt - s_pdone), 32'd0);
    chk_eq("R4", "words taken at done", 32'(acc_at_done - s_acc), 32'd0);
    chk_eq("R10", "cfg_valid held", {31'b0, cfg_valid}, 32'd1);
    chk_eq("R10", "cfg_data held", cfg_data, mem_word(32'h0000_3000));
    sink_mode = 2'd0;
    settle(20);
    chk_eq("R10", "word released", 32'(acc_cnt - s_acc), 32'd1);
  endtask

  task automatic t_backpressure();
    sink_mode = 2'd2;
    mem_slow = 1'b1;
    snap();
    send_cmd(32'h0000_4001, 32'hFFFF_FFFF, 32'd6, 32'd0);
    settle(300);
    chk_eq("R10", "words under back-pressure", 32'(acc_cnt - s_acc), 32'd6);
    chk_words("R10", s_acc, 32'h0000_4000, 6);
    chk_eq("R3", "port done after drain", 32'(pdone_cnt - s_pdone), 32'd1);
    sink_mode = 2'd0;
    mem_slow = 1'b0;
  endtask

  task automatic t_queue();
    sink_mode = 2'd1;
    snap();
    send_cmd(32'h0000_5000, 32'hFFFF_FFFF, 32'd1, 32'd0);
    settle(20);
    send_cmd(32'h0000_5100, 32'hFFFF_FFFF, 32'd1, 32'd0);
    settle(20);
    for (int k = 0; k < 4; k++)
      send_cmd(32'h0000_5200 + 32'(k * 256), 32'hFFFF_FFFF, 32'd1, 32'd0);
    settle(5);
    chk_eq("R6", "status with four queued", status_word, 32'h8000_0000);
    send_cmd(32'h0000_5600, 32'hFFFF_FFFF, 32'd1, 32'd0);
    settle(5);
    chk_eq("R7", "overflow pulses", 32'(ovf_cnt - s_ovf), 32'd1);
    sink_mode = 2'd0;
    settle(300);
    chk_eq("R7", "words after drain", 32'(acc_cnt - s_acc), 32'd6);
    for (int k = 0; k < 6; k++)
      chk_eq("R6", $sformatf("queue order word %0d", k), got[(s_acc + k) % 256],
             mem_word(32'h0000_5000 + 32'(k * 256)));
    chk_eq("R6", "status after drain", status_word, 32'h4000_0000);
  endtask

  task automatic t_sequence_rules();
    snap();
    wr_reg(A_SRC, 32'h0000_6001);
    wr_reg(A_SLEN, 32'd1);
    wr_reg(A_DLEN, 32'd0);
    settle(50);
    chk_eq("R1", "skipped step queues nothing", 32'(acc_cnt - s_acc), 32'd0);
    chk_eq("R1", "skipped step no done", 32'(done_cnt - s_done), 32'd0);
    chk_eq("R1", "skipped step no reads", 32'(req_cnt - s_req), 32'd0);
    snap();
    wr_reg(A_SRC, 32'h0000_7000);
    wr_reg(A_DST, 32'hFFFF_FFFF);
    wr_reg(A_SRC, 32'h0000_6101);
    wr_reg(A_DST, 32'hFFFF_FFFF);
    wr_reg(A_SLEN, 32'd1);
    wr_reg(A_DLEN, 32'd0);
    settle(60);
    chk_eq("R1", "restart word count", 32'(acc_cnt - s_acc), 32'd1);
    chk_words("R1", s_acc, 32'h0000_6100, 1);
  endtask

  task automatic t_dst_reject();
    snap();
    send_cmd(32'h0000_7001, 32'h0000_1000, 32'd1, 32'd0);
    send_cmd(32'h0000_7001, 32'hFFFF_FFFF, 32'd1, 32'd5);
    settle(50);
    chk_eq("R5", "reject pulses", 32'(cerr_cnt - s_cerr), 32'd2);
    chk_eq("R5", "rejected reads", 32'(req_cnt - s_req), 32'd0);
    chk_eq("R5", "status empty", status_word, 32'h4000_0000);
  endtask

  task automatic t_lengths();
    snap();
    send_cmd(32'h0000_8001, 32'hFFFF_FFFF, 32'd0, 32'd0);
    settle(30);
    chk_eq("R2", "zero length done", 32'(done_cnt - s_done), 32'd1);
    chk_eq("R2", "zero length port done", 32'(pdone_cnt - s_pdone), 32'd1);
    chk_eq("R2", "zero length reads", 32'(req_cnt - s_req), 32'd0);
    snap();
    send_cmd(32'h0000_8101, 32'hFFFF_FFFF, 32'hF800_0002, 32'd0);
    settle(120);
    chk_eq("R2", "masked length words", 32'(acc_cnt - s_acc), 32'd2);
    chk_words("R2", s_acc, 32'h0000_8100, 2);
  endtask

  task automatic t_read_err();
    err_addr = 32'h0000_9004;
    snap();
    send_cmd(32'h0000_9001, 32'hFFFF_FFFF, 32'd3, 32'd0);
    settle(100);
    chk_eq("R9", "words before error", 32'(acc_cnt - s_acc), 32'd1);
    chk_eq("R9", "read error pulses", 32'(rerr_cnt - s_rerr), 32'd1);
    chk_eq("R9", "no done on abort", 32'(done_cnt - s_done), 32'd0);
    snap();
    send_cmd(32'h0000_A001, 32'hFFFF_FFFF, 32'd1, 32'd0);
    settle(60);
    chk_eq("R9", "next command done", 32'(done_cnt - s_done), 32'd1);
    chk_words("R9", s_acc, 32'h0000_A000, 1);
    err_addr = 32'hFFFF_FFFF;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (evt_dma_done || evt_port_done || evt_rd_err || evt_q_overflow || evt_cmd_err)
        evt_at_reset++;
    end
    t_reset();
    t_last_cmd();
    t_misaligned();
    t_nonlast_stall();
    t_backpressure();
    t_queue();
    t_sequence_rules();
    t_dst_reject();
    t_lengths();
    t_read_err();
    finish_sim();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    finish_sim();
  end

endmodule